// File: doc/BRIEF.md
# Segmented Transfer Ring Descriptor Fetcher

This block reads work items from a circular ring in memory. Another agent fills the ring. Each entry is a 16-byte transfer request block (TRB). A transfer descriptor is one or more consecutive non-link TRBs, joined by their chain flags. When firmware raises a dequeue request, the block reads TRBs one at a time through a 128-bit memory read port.

- Ownership is decided by comparing each entry's cycle flag with a consumer cycle flag held in the block.
- Link entries send the walk to another segment and may invert the expected cycle flag.
- Collected entries are held inside the block until the descriptor is known to be complete. Only then are they streamed out, each with the address it was read from.
- Every request ends with a one-cycle status pulse.

The committed dequeue pointer and cycle flag change only when a descriptor completes. Any other outcome leaves them as they were, so a later request retries from the same place. Firmware can load both values while the block is idle.

The controller is a state machine with six states:

- `S_IDLE` waits for a request and applies firmware writes.
- `S_FETCH` presents a read address until it is accepted.
- `S_WAIT` waits for and captures the response.
- `S_EVAL` classifies the entry. Its transitions are:
  - append-and-continue or follow-link go to `S_FETCH`;
  - append-last goes to `S_EMIT`;
  - memory error, empty, too long and pointer overflow go to `S_FINISH`.
- `S_EMIT` streams the held entries. After the beat marked last is accepted it goes to `S_FINISH`.
- `S_FINISH` pulses the status, commits on success, and returns to `S_IDLE`.

Top module: `trb_ring_dequeue`

## Requirements
- R1: After reset the committed pointer and cycle flag are zero, `busy` is low, and no read, output beat or status pulse is presented.
- R2: While idle, `set_ptr_en` loads the committed pointer with `{set_ptr_val, 4'b0000}` and `set_cyc_en` loads the cycle flag. A request in the same cycle starts from the newly written values. Both writes and further requests are ignored while `busy` is high.
- R3: At most one memory read is outstanding at a time. The read address is held stable until `mem_rd_ready` is seen. Field positions in a 128-bit entry:
  - bit 96 is the cycle flag;
  - bit 97 is the toggle flag of a link;
  - bit 100 is the chain flag;
  - bits 111:106 are the type, where 6 means link;
  - the segment pointer is `data[ADDR_W-1:4]` followed by four zero bits.
- R4: An entry whose cycle flag differs from the expected one means the ring is empty. The request ends with status 1 (empty), and the committed state is unchanged.
- R5: A valid link entry redirects the walk to its segment pointer and inverts the expected cycle flag when its toggle flag is set. The link entry itself is never emitted.
- R6: Each valid non-link entry is collected with its read address, and the walk pointer moves on by 16. Collection ends at the first entry with the chain flag clear. The entries are then streamed in order, with `trb_last` high only on the final one, and the beat is held stable while `trb_ready` is low.
- R7: A descriptor may span segments through link entries. Example: two chained entries, a link, then two entries whose last has chain clear, form one four-entry descriptor.
- R8: A completed descriptor ends with status 0 (done), after its last beat. The committed pointer then points just past the last collected entry, and the committed cycle flag takes the walk's flag.
- R9: If the ring runs empty after some entries were collected, nothing is streamed. The status is 1 and the committed state is unchanged.
- R10: If advancing past a valid non-link entry would carry out of the `ADDR_W`-bit address, the request ends with status 2 (bad pointer), with no output and no commit.
- R11: A read response with `mem_rsp_err` set ends the request with status 3 (memory error), with no output and no commit.
- R12: More than `MAX_TRBS` (16) chained entries, or more than `MAX_LINKS` (4) followed links in one request, ends the request with status 4 (too long), with no output and no commit.
- R13: Every accepted request produces exactly one single-cycle `done_valid` pulse, after which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deq_req | input | 1 | Start one dequeue (taken only when idle) |
| busy | output | 1 | A dequeue is in progress |
| set_ptr_en | input | 1 | Load committed pointer (idle only) |
| set_ptr_val | input | ADDR_W-4 | Pointer value in 16-byte units |
| set_cyc_en | input | 1 | Load committed cycle flag (idle only) |
| set_cyc_val | input | 1 | Cycle flag value |
| deq_ptr | output | ADDR_W | Committed dequeue pointer |
| cycle_state | output | 1 | Committed consumer cycle flag |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read data (one entry) |
| mem_rsp_err | input | 1 | Read failed |
| trb_valid | output | 1 | Output entry valid |
| trb_ready | input | 1 | Output entry accepted |
| trb_data | output | 128 | Output entry contents |
| trb_addr | output | ADDR_W | Address the entry was read from |
| trb_last | output | 1 | Final entry of the descriptor |
| done_valid | output | 1 | One-cycle end-of-request pulse |
| done_status | output | 3 | 0 done, 1 empty, 2 bad pointer, 3 memory error, 4 too long |

## Verification
A wrong expected cycle flag or walk pointer shows up at the port on the next request. It appears either as a status of empty where a descriptor was due, or as beats whose address or payload differ from the reference walk. A commit on the wrong outcome shows in `deq_ptr` and `cycle_state` in the cycle after the status pulse. A broken collection count shows as a wrong beat count or a misplaced `trb_last` within the same request. Random rings mixed with directed links, toggles, caps, overflow and read errors reach each of these paths.

// File: rtl/trbq_pkg.sv
package trbq_pkg;

    localparam int TRB_W     = 128;
    localparam int CYC_POS   = 96;
    localparam int TGL_POS   = 97;
    localparam int CHN_POS   = 100;
    localparam int TYPE_LO   = 106;
    localparam int TYPE_W    = 6;
    localparam int LINK_CODE = 6;
    localparam int ENTRY_B   = 16;

    typedef enum logic [2:0] {
        ST_DONE    = 3'd0,
        ST_EMPTY   = 3'd1,
        ST_BADPTR  = 3'd2,
        ST_MEMERR  = 3'd3,
        ST_TOOLONG = 3'd4
    } deq_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_EVAL,
        S_EMIT,
        S_FINISH
    } deq_state_e;

    typedef enum logic [2:0] {
        EV_MEMERR,
        EV_EMPTY,
        EV_LINK,
        EV_LINKCAP,
        EV_CAP,
        EV_OVF,
        EV_APPEND_MORE,
        EV_APPEND_LAST
    } eval_e;

endpackage

// File: rtl/trbq_ptr_step.sv
module trbq_ptr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 16
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt,
    output logic              ovf
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;

    assign sum = {1'b0, cur} + SUM_W'(STEP);
    assign nxt = sum[ADDR_W-1:0];
    assign ovf = sum[ADDR_W];

endmodule

// File: rtl/trbq_desc_buf.sv
module trbq_desc_buf #(
    parameter int DEPTH = 16,
    parameter int DW    = 128,
    parameter int AW    = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [AW-1:0]            wr_addr,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [AW-1:0]            rd_addr
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0] d_arr [DEPTH];
    logic [AW-1:0] a_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DW-1:0] d_q;
        logic [AW-1:0] a_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                d_q <= wr_data;
                a_q <= wr_addr;
            end
        end
        assign d_arr[i] = d_q;
        assign a_arr[i] = a_q;
    end

    assign rd_data = d_arr[rd_idx];
    assign rd_addr = a_arr[rd_idx];

endmodule

// File: rtl/trb_ring_dequeue.sv
module trb_ring_dequeue
    import trbq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_TRBS  = 16,
    parameter int MAX_LINKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deq_req,
    output logic              busy,
    input  logic              set_ptr_en,
    input  logic [ADDR_W-5:0] set_ptr_val,
    input  logic              set_cyc_en,
    input  logic              set_cyc_val,
    output logic [ADDR_W-1:0] deq_ptr,
    output logic              cycle_state,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [127:0]      mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              trb_valid,
    input  logic              trb_ready,
    output logic [127:0]      trb_data,
    output logic [ADDR_W-1:0] trb_addr,
    output logic              trb_last,
    output logic              done_valid,
    output logic [2:0]        done_status
);
    localparam int IDX_W  = $clog2(MAX_TRBS);
    localparam int CNT_W  = $clog2(MAX_TRBS + 1);
    localparam int LCNT_W = $clog2(MAX_LINKS + 1);

    deq_state_e        state_q, state_d;
    deq_status_e       stat_q;
    eval_e             ev;

    logic [ADDR_W-1:0] cptr_q, wptr_q;
    logic              ccyc_q, wcyc_q;
    logic [TRB_W-1:0]  rdata_q;
    logic              rerr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LCNT_W-1:0] lcnt_q;

    // fields of the captured entry
    logic              f_cyc, f_tgl, f_chain, f_link;
    logic [ADDR_W-1:0] f_seg;
    logic [ADDR_W-1:0] ptr_next;
    logic              ptr_ovf;
    logic              buf_we;
    logic [TRB_W-1:0]  buf_rd_data;
    logic [ADDR_W-1:0] buf_rd_addr;
    logic              last_beat;
    logic [ADDR_W-1:0] set_ptr_full;

    assign f_cyc        = rdata_q[CYC_POS];
    assign f_tgl        = rdata_q[TGL_POS];
    assign f_chain      = rdata_q[CHN_POS];
    assign f_link       = (rdata_q[TYPE_LO +: TYPE_W] == TYPE_W'(LINK_CODE));
    assign f_seg        = {rdata_q[ADDR_W-1:4], 4'b0000};
    assign set_ptr_full = {set_ptr_val, 4'b0000};
    assign last_beat    = (cnt_q == (CNT_W'(idx_q) + CNT_W'(1)));

    trbq_ptr_step #(
        .ADDR_W (ADDR_W),
        .STEP   (ENTRY_B)
    ) u_step (
        .cur (wptr_q),
        .nxt (ptr_next),
        .ovf (ptr_ovf)
    );

    trbq_desc_buf #(
        .DEPTH (MAX_TRBS),
        .DW    (TRB_W),
        .AW    (ADDR_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (IDX_W'(cnt_q)),
        .wr_data (rdata_q),
        .wr_addr (wptr_q),
        .rd_idx  (idx_q),
        .rd_data (buf_rd_data),
        .rd_addr (buf_rd_addr)
    );

    // classify the captured entry
    always_comb begin
        if (rerr_q) begin
            ev = EV_MEMERR;
        end else if (f_cyc != wcyc_q) begin
            ev = EV_EMPTY;
        end else if (f_link) begin
            ev = (lcnt_q == LCNT_W'(MAX_LINKS)) ? EV_LINKCAP : EV_LINK;
        end else if (cnt_q == CNT_W'(MAX_TRBS)) begin
            ev = EV_CAP;
        end else if (ptr_ovf) begin
            ev = EV_OVF;
        end else if (f_chain) begin
            ev = EV_APPEND_MORE;
        end else begin
            ev = EV_APPEND_LAST;
        end
    end

    assign buf_we = (state_q == S_EVAL) &&
                    ((ev == EV_APPEND_MORE) || (ev == EV_APPEND_LAST));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (deq_req) state_d = S_FETCH;
            S_FETCH:  if (mem_rd_ready) state_d = S_WAIT;
            S_WAIT:   if (mem_rsp_valid) state_d = S_EVAL;
            S_EVAL: begin
                unique case (ev)
                    EV_LINK, EV_APPEND_MORE: state_d = S_FETCH;
                    EV_APPEND_LAST:          state_d = S_EMIT;
                    default:                 state_d = S_FINISH;
                endcase
            end
            S_EMIT:   if (trb_ready && last_beat) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cptr_q  <= '0;
            ccyc_q  <= 1'b0;
            wptr_q  <= '0;
            wcyc_q  <= 1'b0;
            rdata_q <= '0;
            rerr_q  <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            lcnt_q  <= '0;
            stat_q  <= ST_DONE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (set_ptr_en) cptr_q <= set_ptr_full;
                    if (set_cyc_en) ccyc_q <= set_cyc_val;
                    if (deq_req) begin
                        wptr_q <= set_ptr_en ? set_ptr_full : cptr_q;
                        wcyc_q <= set_cyc_en ? set_cyc_val : ccyc_q;
                        cnt_q  <= '0;
                        idx_q  <= '0;
                        lcnt_q <= '0;
                    end
                end
                S_FETCH: ;
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        rdata_q <= mem_rsp_data;
                        rerr_q  <= mem_rsp_err;
                    end
                end
                S_EVAL: begin
                    unique case (ev)
                        EV_MEMERR:  stat_q <= ST_MEMERR;
                        EV_EMPTY:   stat_q <= ST_EMPTY;
                        EV_LINKCAP: stat_q <= ST_TOOLONG;
                        EV_CAP:     stat_q <= ST_TOOLONG;
                        EV_OVF:     stat_q <= ST_BADPTR;
                        EV_LINK: begin
                            wptr_q <= f_seg;
                            wcyc_q <= wcyc_q ^ f_tgl;
                            lcnt_q <= lcnt_q + LCNT_W'(1);
                        end
                        EV_APPEND_MORE: begin
                            wptr_q <= ptr_next;
                            cnt_q  <= cnt_q + CNT_W'(1);
                        end
                        EV_APPEND_LAST: begin
                            wptr_q <= ptr_next;
                            cnt_q  <= cnt_q + CNT_W'(1);
                            stat_q <= ST_DONE;
                        end
                        default: ;
                    endcase
                end
                S_EMIT: begin
                    if (trb_ready && !last_beat) idx_q <= idx_q + IDX_W'(1);
                end
                S_FINISH: begin
                    if (stat_q == ST_DONE) begin
                        cptr_q <= wptr_q;
                        ccyc_q <= wcyc_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != S_IDLE);
        mem_rd_valid = (state_q == S_FETCH);
        mem_rd_addr  = wptr_q;
        trb_valid    = (state_q == S_EMIT);
        trb_data     = buf_rd_data;
        trb_addr     = buf_rd_addr;
        trb_last     = (state_q == S_EMIT) && last_beat;
        done_valid   = (state_q == S_FINISH);
        done_status  = stat_q;
        deq_ptr      = cptr_q;
        cycle_state  = ccyc_q;
    end

endmodule

// File: rtl/trb_ring_dequeue_chk.sv
module trb_ring_dequeue_chk
    import trbq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] deq_ptr,
    input logic              cycle_state,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              trb_valid,
    input logic              trb_ready,
    input logic [127:0]      trb_data,
    input logic [ADDR_W-1:0] trb_addr,
    input logic              trb_last,
    input logic              done_valid,
    input logic [2:0]        done_status
);

    a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_valid) |=> ($stable(deq_ptr) && $stable(cycle_state)));

    a_r3_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r6_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trb_valid && !trb_ready) |=>
            (trb_valid && $stable(trb_data) && $stable(trb_addr) && $stable(trb_last)));

    a_r6_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        trb_valid |-> (trb_addr[3:0] == 4'h0));

    a_r3_no_read_while_emitting: assert property (@(posedge clk) disable iff (!rst_n)
        !(trb_valid && mem_rd_valid));

    a_r8_no_commit_on_failure: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && (done_status != 3'(ST_DONE))) |=>
            ($stable(deq_ptr) && $stable(cycle_state)));

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && !busy));

endmodule

bind trb_ring_dequeue trb_ring_dequeue_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .deq_ptr      (deq_ptr),
    .cycle_state  (cycle_state),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .trb_valid    (trb_valid),
    .trb_ready    (trb_ready),
    .trb_data     (trb_data),
    .trb_addr     (trb_addr),
    .trb_last     (trb_last),
    .done_valid   (done_valid),
    .done_status  (done_status)
);

// File: tb/trb_ring_dequeue_tb_top.sv
`timescale 1ns/1ps
module trb_ring_dequeue_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          deq_req = 1'b0;
    logic          busy;
    logic          set_ptr_en = 1'b0;
    logic [AW-5:0] set_ptr_val = '0;
    logic          set_cyc_en = 1'b0;
    logic          set_cyc_val = 1'b0;
    logic [AW-1:0] deq_ptr;
    logic          cycle_state;
    logic          mem_rd_valid;
    logic          mem_rd_ready = 1'b0;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [127:0]  mem_rsp_data = '0;
    logic          mem_rsp_err = 1'b0;
    logic          trb_valid;
    logic          trb_ready = 1'b0;
    logic [127:0]  trb_data;
    logic [AW-1:0] trb_addr;
    logic          trb_last;
    logic          done_valid;
    logic [2:0]    done_status;

    always #10 clk = ~clk;

    trb_ring_dequeue #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .deq_req(deq_req), .busy(busy),
        .set_ptr_en(set_ptr_en), .set_ptr_val(set_ptr_val),
        .set_cyc_en(set_cyc_en), .set_cyc_val(set_cyc_val),
        .deq_ptr(deq_ptr), .cycle_state(cycle_state),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .trb_valid(trb_valid), .trb_ready(trb_ready), .trb_data(trb_data),
        .trb_addr(trb_addr), .trb_last(trb_last),
        .done_valid(done_valid), .done_status(done_status)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [127:0] mem [256];
    bit           err_en = 0;
    logic [31:0]  err_addr = '0;
    bit           stall_out = 0;

    // memory responder state
    bit           pend = 0;
    int           pend_dly = 0;
    logic [31:0]  pend_addr = '0;

    // captured outputs
    logic [127:0] cap_data [32];
    logic [31:0]  cap_addr [32];
    bit           cap_last [32];
    int           cap_n = 0;
    int           done_cnt = 0;
    logic [2:0]   got_status = '0;

    // reference state
    logic [31:0]  m_ptr = '0;
    bit           m_cyc = 0;
    logic [127:0] exp_data [17];
    logic [31:0]  exp_addr [17];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_trb(input logic [31:0] tag, input logic [31:0] param,
                                            input bit cyc, input bit chain,
                                            input bit link, input bit tgl);
        logic [5:0]  ty;
        logic [31:0] w3;
        ty = link ? 6'd6 : 6'd1;
        w3 = {16'h0, ty, 5'b0, chain, 2'b0, tgl, cyc};
        return {w3, tag, 32'h0, param};
    endfunction

    // reference walk: R4..R12
    task automatic model_run(output int n, output logic [2:0] st);
        logic [31:0]  p;
        bit           c;
        int           links;
        logic [127:0] d;
        bit           fin;
        p = m_ptr; c = m_cyc; links = 0; n = 0; st = 3'd1; fin = 0;
        while (!fin) begin
            d = mem[p[11:4]];
            if (err_en && p == err_addr) begin st = 3'd3; fin = 1; end
            else if (d[96] != c) begin st = 3'd1; fin = 1; end
            else if (d[111:106] == 6'd6) begin
                if (links == 4) begin st = 3'd4; fin = 1; end
                else begin p = {d[31:4], 4'b0}; c = c ^ d[97]; links++; end
            end
            else if (n == 16) begin st = 3'd4; fin = 1; end
            else if (p == 32'hFFFF_FFF0) begin st = 3'd2; fin = 1; end
            else begin
                exp_data[n] = d; exp_addr[n] = p; n++; p = p + 32'd16;
                if (!d[100]) begin st = 3'd0; fin = 1; m_ptr = p; m_cyc = c; end
            end
        end
        if (st != 3'd0) n = 0;
    endtask

    // environment: memory port, output ready, capture
    always @(negedge clk) begin
        cycles++;
        trb_ready = stall_out ? 1'b0 : ($urandom % 4 != 0);
        if (trb_valid && trb_ready && cap_n < 32) begin
            cap_data[cap_n] = trb_data;
            cap_addr[cap_n] = trb_addr;
            cap_last[cap_n] = trb_last;
            cap_n++;
        end
        if (done_valid) begin
            done_cnt++;
            got_status = done_status;
        end
        if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err = 1'b0;
        end
        if (pend) begin
            if (pend_dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem[pend_addr[11:4]];
                mem_rsp_err = err_en && (pend_addr == err_addr);
                pend = 0;
            end else begin
                pend_dly--;
            end
        end
        mem_rd_ready = ($urandom % 4 != 0);
        if (mem_rd_valid && mem_rd_ready && !pend) begin
            pend = 1;
            pend_dly = $urandom % 3;
            pend_addr = mem_rd_addr;
        end
    end

    task automatic set_ctl(input logic [31:0] p, input bit c);
        @(negedge clk);
        set_ptr_en = 1'b1; set_ptr_val = p[31:4];
        set_cyc_en = 1'b1; set_cyc_val = c;
        @(negedge clk);
        set_ptr_en = 1'b0; set_cyc_en = 1'b0;
        m_ptr = {p[31:4], 4'b0}; m_cyc = c;
    endtask

    task automatic wait_done(input string req, input int base);
        int t;
        t = 0;
        while (done_cnt == base && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(done_cnt == base + 1, req, "status pulse seen", 128'(done_cnt), 128'(base + 1));
    endtask

    // one full request compared against the reference walk
    task automatic run_deq(input string req, output int n_out);
        int         n;
        logic [2:0] st;
        int         base;
        bit         ok;
        model_run(n, st);
        cap_n = 0;
        base = done_cnt;
        @(negedge clk);
        deq_req = 1'b1;
        @(negedge clk);
        deq_req = 1'b0;
        wait_done(req, base);
        chk(got_status == st, req, "status", 128'(got_status), 128'(st));
        chk(cap_n == n, req, "beat count", 128'(cap_n), 128'(n));
        ok = (cap_n == n);
        for (int i = 0; i < n && i < cap_n; i++) begin
            if (cap_data[i] != exp_data[i] || cap_addr[i] != exp_addr[i] ||
                cap_last[i] != (i == n - 1)) ok = 0;
        end
        chk(ok, req, "beats data/addr/last", cap_n > 0 ? cap_data[0] : '0,
            n > 0 ? exp_data[0] : '0);
        chk(deq_ptr == m_ptr && cycle_state == m_cyc, req, "committed ptr/cycle",
            {cycle_state, deq_ptr}, {m_cyc, m_ptr});
        n_out = n;
    endtask

    task automatic fill_random(input bit pc);
        for (int i = 16; i < 64; i++) begin
            int  r;
            bit  c;
            r = $urandom % 100;
            c = ($urandom % 100 < 90) ? pc : ~pc;
            if (r < 12)
                mem[i] = mk_trb(32'(i), 32'(16 + $urandom % 48) << 4, c, 1'b0, 1'b1,
                                ($urandom % 4 == 0));
            else
                mem[i] = mk_trb($urandom, 32'($urandom), c, ($urandom % 100 < 55), 1'b0, 1'b0);
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(deq_ptr == 0 && cycle_state == 0, "R1", "reset ptr/cycle",
            {cycle_state, deq_ptr}, '0);
        chk(!busy && !mem_rd_valid && !trb_valid && !done_valid, "R1", "reset idle outputs",
            {busy, mem_rd_valid, trb_valid, done_valid}, '0);

        // R4 empty at start: all-zero memory with expected cycle 1
        set_ctl(32'h0000_0500, 1'b1);
        run_deq("R4", n);

        // R7 cross-segment descriptor, R5 links skipped
        mem[64] = mk_trb(32'd1, 32'h0, 0, 1, 0, 0);
        mem[65] = mk_trb(32'd2, 32'h0, 0, 1, 0, 0);
        mem[66] = mk_trb(32'd90, 32'h480, 0, 0, 1, 0);
        mem[72] = mk_trb(32'd3, 32'h0, 0, 1, 0, 0);
        mem[73] = mk_trb(32'd4, 32'h0, 0, 0, 0, 0);
        mem[74] = mk_trb(32'd91, 32'h500, 0, 0, 1, 0);
        mem[80] = mk_trb(32'd5, 32'h0, 0, 1, 0, 0);
        mem[81] = mk_trb(32'd6, 32'h0, 0, 0, 0, 0);
        mem[82] = mk_trb(32'd92, 32'h400, 0, 0, 1, 0);
        set_ctl(32'h0000_0400, 1'b0);
        run_deq("R7", n);
        chk(n == 4 && cap_n == 4 && cap_addr[2] == 32'h480, "R7", "four entries across link",
            128'(cap_n), 128'd4);
        run_deq("R6", n);
        chk(cap_n == 2 && deq_ptr == 32'h520, "R8", "pointer past last entry",
            128'(deq_ptr), 128'h520);

        // R5 toggle link inverts expected cycle
        mem[90] = mk_trb(32'd7, 32'h0, 0, 1, 0, 0);
        mem[91] = mk_trb(32'd93, 32'h600, 0, 0, 1, 1);
        mem[96] = mk_trb(32'd8, 32'h0, 1, 0, 0, 0);
        mem[97] = mk_trb(32'd9, 32'h0, 0, 0, 0, 0);
        set_ctl(32'h0000_05A0, 1'b0);
        run_deq("R5", n);
        chk(cycle_state == 1'b1 && cap_n == 2, "R5", "cycle flag toggled", 128'(cycle_state), 128'd1);
        run_deq("R4", n);

        // R9 partial descriptor then empty
        mem[160] = mk_trb(32'd10, 32'h0, 0, 1, 0, 0);
        mem[161] = mk_trb(32'd11, 32'h0, 0, 1, 0, 0);
        mem[162] = mk_trb(32'd12, 32'h0, 1, 0, 0, 0);
        set_ctl(32'h0000_0A00, 1'b0);
        run_deq("R9", n);
        chk(cap_n == 0 && deq_ptr == 32'hA00, "R9", "no beats, no commit", 128'(cap_n), 128'd0);

        // R11 read error
        mem[170] = mk_trb(32'd13, 32'h0, 0, 1, 0, 0);
        mem[171] = mk_trb(32'd14, 32'h0, 0, 0, 0, 0);
        err_en = 1; err_addr = 32'h0000_0AB0;
        set_ctl(32'h0000_0AA0, 1'b0);
        run_deq("R11", n);
        err_en = 0;
        run_deq("R11", n);

        // R10 pointer overflow
        mem[255] = mk_trb(32'd15, 32'h0, 0, 0, 0, 0);
        set_ctl(32'hFFFF_FFF0, 1'b0);
        run_deq("R10", n);
        chk(got_status == 3'd2, "R10", "bad pointer status", 128'(got_status), 128'd2);

        // R12 exactly 16 entries, then 17 chained
        for (int i = 0; i < 16; i++) mem[128 + i] = mk_trb(32'(100 + i), 32'h0, 0, (i != 15), 0, 0);
        set_ctl(32'h0000_0800, 1'b0);
        run_deq("R12", n);
        chk(cap_n == 16, "R12", "sixteen entries allowed", 128'(cap_n), 128'd16);
        mem[143] = mk_trb(32'd115, 32'h0, 0, 1, 0, 0);
        mem[144] = mk_trb(32'd116, 32'h0, 0, 0, 0, 0);
        set_ctl(32'h0000_0800, 1'b0);
        run_deq("R12", n);
        chk(got_status == 3'd4, "R12", "chain too long", 128'(got_status), 128'd4);

        // R12 link loop
        mem[100] = mk_trb(32'd94, 32'h640, 0, 0, 1, 0);
        set_ctl(32'h0000_0640, 1'b0);
        run_deq("R12", n);
        chk(got_status == 3'd4, "R12", "link loop capped", 128'(got_status), 128'd4);

        // R2 write and request in the same cycle start from the new pointer
        @(negedge clk);
        set_ptr_en = 1'b1; set_ptr_val = 28'h0000040; set_cyc_en = 1'b1; set_cyc_val = 1'b0;
        deq_req = 1'b1;
        m_ptr = 32'h400; m_cyc = 0;
        model_run(n, got_status);
        cap_n = 0;
        @(negedge clk);
        set_ptr_en = 1'b0; set_cyc_en = 1'b0; deq_req = 1'b0;
        wait_done("R2", done_cnt - (done_valid ? 1 : 0) - 0);
        chk(cap_n == 4 && cap_addr[0] == 32'h400, "R2", "same-cycle write used",
            128'(cap_addr[0]), 128'h400);

        // R2/R13 writes and requests ignored while busy
        begin
            int base;
            base = done_cnt;
            model_run(n, got_status);
            cap_n = 0;
            stall_out = 1;
            @(negedge clk); deq_req = 1'b1;
            @(negedge clk); deq_req = 1'b0;
            while (!trb_valid) @(negedge clk);
            set_ptr_en = 1'b1; set_ptr_val = 28'h0000088; set_cyc_en = 1'b1; set_cyc_val = 1'b1;
            deq_req = 1'b1;
            @(negedge clk);
            set_ptr_en = 1'b0; set_cyc_en = 1'b0; deq_req = 1'b0;
            stall_out = 0;
            wait_done("R13", base);
            repeat (30) @(negedge clk);
            chk(done_cnt == base + 1, "R13", "one pulse per request", 128'(done_cnt), 128'(base + 1));
            chk(deq_ptr == m_ptr && cycle_state == m_cyc, "R2", "busy-time write ignored",
                {cycle_state, deq_ptr}, {m_cyc, m_ptr});
        end

        // random rings
        for (int round = 0; round < 20; round++) begin
            bit pc;
            pc = $urandom % 2;
            fill_random(pc);
            set_ctl(32'h0000_0100 + (32'($urandom % 48) << 4), pc);
            for (int k = 0; k < 6; k++) run_deq("R6", n);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        while (cycles < 150000) @(negedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule